// File: doc/BRIEF.md
# Tag-Broadcast Renaming Slot Buffer

This block sits between a renaming decode stage and a set of execution units. Each decoded instruction takes one entry in a circular buffer of slots. The slot number is the instruction's tag. A rename table records, for every architectural register, one of two things: a value that is ready, or the tag of the slot that will produce that value. When an instruction is allocated, its two sources are looked up in that table. A source that is not ready is stored as the tag it waits on.

Units return results on a shared bus that carries a tag and data. Every waiting source whose tag matches takes the data. A rename entry that still points at that tag is turned back into a plain value. When a slot's use bit is set, it has not yet started, and both of its sources are present, it is offered on the dispatch port. The oldest such slot wins.

A separate completion input frees a slot. Storage is reclaimed strictly in order. A deallocation pointer moves forward only over slots that have been freed, so a younger instruction that completes early does not return its slot until every older one ahead of it is free.

Top module: `rename_slot_buffer`

## Requirements
- R1: After reset, `alloc_ready` is 1, `alloc_tag` is 0 and `disp_valid` is 0. Every architectural register i holds the ready value i.
- R2: Each accepted allocation returns as its tag the current slot index. Tags run 0, 1, 2 and so on, and wrap modulo SLOTS.
- R3: A source register whose latest writer has not broadcast yet is captured as that writer's tag. The slot is not offered until that tag appears on the result bus. When it is offered, the operand equals the broadcast data.
- R4: A slot is offered only if its use bit is set, its exec bit is clear, and both sources are present. Accepting the offer sets the exec bit, so the slot is never offered again. A slot that is not ready is skipped in favour of a later slot that is ready.
- R5: Among ready slots, the one offered is the nearest to the deallocation pointer in circular order, which makes it the oldest.
- R6: A result broadcast turns a rename entry holding the matching tag back into a value. A later reader of that register gets the data at once and becomes ready without waiting.
- R7: A broadcast of a tag that a younger writer has since replaced in the rename table leaves the mapping unchanged. A reader after the younger writer keeps waiting for the younger tag.
- R8: If an allocation reads a register whose pending tag is on the result bus in the same cycle, the new slot captures the data and is ready on the next cycle.
- R9: When all SLOTS slots are held, `alloc_ready` is 0. A request made while `alloc_ready` is 0 allocates nothing, and `alloc_tag` does not change.
- R10: Space is returned in order. Completing a younger slot while the slot at the deallocation pointer is still in use leaves `alloc_ready` at 0. Once the oldest slot completes, `alloc_ready` rises after one further cycle.
- R11: After a full wrap, a freed slot index is handed out again as a new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Decode presents an instruction |
| alloc_op | input | 4 | Opcode of the new instruction |
| alloc_dst | input | 3 | Destination architectural register |
| alloc_src_a | input | 3 | First source register |
| alloc_src_b | input | 3 | Second source register |
| alloc_ready | output | 1 | A slot is free for allocation |
| alloc_tag | output | 3 | Tag the next allocation receives |
| disp_valid | output | 1 | A ready slot is offered |
| disp_accept | input | 1 | The unit takes the offered slot |
| disp_tag | output | 3 | Tag of the offered slot |
| disp_op | output | 4 | Opcode of the offered slot |
| disp_opnd_a | output | 16 | First operand value |
| disp_opnd_b | output | 16 | Second operand value |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | 3 | Tag of the producing slot |
| res_data | input | 16 | Result value |
| done_valid | input | 1 | A slot's instruction has completed |
| done_tag | input | 3 | Tag of the completed slot |

## Verification
Two collisions matter most. The first is a result broadcast landing in the same cycle as an allocation that reads the register being produced. The bench drives the result and the allocation together and checks that the new slot is offered on the very next cycle with the broadcast value as its operand. The second is a stale broadcast arriving after a younger writer has taken over the same register. The bench broadcasts the older tag, then shows that a later reader still waits, and that it is released only by the younger writer's result.

// File: rtl/rsb_pkg.sv
`timescale 1ns/1ps
package rsb_pkg;
    // SLOTS must be a power of two: pointers wrap by natural overflow.
    localparam int unsigned SLOTS  = 8;
    localparam int unsigned REGS   = 8;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned OP_W   = 4;
    localparam int unsigned TAG_W  = $clog2(SLOTS);
    localparam int unsigned REG_W  = $clog2(REGS);
    localparam int unsigned CNT_W  = $clog2(SLOTS + 1);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OP_W-1:0]   op_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // When present is clear, the low TAG_W bits of val name the producer.
    typedef struct packed {
        logic  present;
        data_t val;
    } operand_t;

    typedef struct packed {
        logic     inuse;
        logic     started;
        op_t      op;
        operand_t a;
        operand_t b;
    } slot_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        data_t data;
    } bcast_t;

    function automatic operand_t snoop(operand_t cur, bcast_t bc);
        operand_t r;
        r = cur;
        if (!cur.present && bc.valid && cur.val[TAG_W-1:0] == bc.tag) begin
            r.present = 1'b1;
            r.val     = bc.data;
        end
        return r;
    endfunction

    function automatic operand_t pending(tag_t t);
        operand_t r;
        r.present = 1'b0;
        r.val     = data_t'(t);
        return r;
    endfunction

    function automatic tag_t next_tag(tag_t t);
        return t + tag_t'(1);
    endfunction
endpackage

// File: rtl/rsb_rename_table.sv
`timescale 1ns/1ps
module rsb_rename_table
    import rsb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bcast_t   bc,
    input  logic     wr_en,
    input  reg_t     wr_reg,
    input  tag_t     wr_tag,
    input  reg_t     rd_reg_a,
    input  reg_t     rd_reg_b,
    output operand_t rd_a,
    output operand_t rd_b
);
    operand_t map_q [REGS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < REGS; i++) begin
            if (rst) begin
                map_q[i].present <= 1'b1;
                map_q[i].val     <= data_t'(i);
            end else if (wr_en && wr_reg == reg_t'(i)) begin
                map_q[i] <= pending(wr_tag);
            end else begin
                map_q[i] <= snoop(map_q[i], bc);
            end
        end
    end

    // Reads see a same-cycle broadcast so a new slot never misses it.
    assign rd_a = snoop(map_q[rd_reg_a], bc);
    assign rd_b = snoop(map_q[rd_reg_b], bc);

    // A fresh mapping always starts out pending, whatever the bus carries.
    assert_rename_write_wins_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !map_q[$past(wr_reg)].present);
endmodule

// File: rtl/rsb_slot_array.sv
`timescale 1ns/1ps
module rsb_slot_array
    import rsb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    alloc_en,
    input  tag_t                    alloc_idx,
    input  op_t                     alloc_op,
    input  operand_t                alloc_a,
    input  operand_t                alloc_b,
    input  bcast_t                  bc,
    input  logic                    start_en,
    input  tag_t                    start_idx,
    input  logic                    done_en,
    input  tag_t                    done_idx,
    output logic [SLOTS-1:0]        inuse_vec,
    output logic [SLOTS-1:0]        cand_vec,
    output op_t   [SLOTS-1:0]       op_vec,
    output data_t [SLOTS-1:0]       a_vec,
    output data_t [SLOTS-1:0]       b_vec
);
    slot_t slot_q [SLOTS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (alloc_en && alloc_idx == tag_t'(i)) begin
                slot_q[i].inuse   <= 1'b1;
                slot_q[i].started <= 1'b0;
                slot_q[i].op      <= alloc_op;
                slot_q[i].a       <= alloc_a;
                slot_q[i].b       <= alloc_b;
            end else begin
                slot_q[i].a <= snoop(slot_q[i].a, bc);
                slot_q[i].b <= snoop(slot_q[i].b, bc);
                if (start_en && start_idx == tag_t'(i))
                    slot_q[i].started <= 1'b1;
                if (done_en && done_idx == tag_t'(i))
                    slot_q[i].inuse <= 1'b0;
            end
        end
    end

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_view
            assign inuse_vec[g] = slot_q[g].inuse;
            assign cand_vec[g]  = slot_q[g].inuse && !slot_q[g].started &&
                                  slot_q[g].a.present && slot_q[g].b.present;
            assign op_vec[g]    = slot_q[g].op;
            assign a_vec[g]     = slot_q[g].a.val;
            assign b_vec[g]     = slot_q[g].b.val;

            assert_operand_hold_R3: assert property (@(posedge clk) disable iff (rst)
                (slot_q[g].inuse && slot_q[g].a.present && slot_q[g].b.present &&
                 !(alloc_en && alloc_idx == tag_t'(g)))
                |=> (slot_q[g].a.present && slot_q[g].b.present));
        end
    endgenerate

    assert_start_is_candidate_R4: assert property (@(posedge clk) disable iff (rst)
        start_en |-> cand_vec[start_idx]);

    assert_start_sticks_R4: assert property (@(posedge clk) disable iff (rst)
        start_en |=> slot_q[$past(start_idx)].started);

    assert_done_live_R10: assert property (@(posedge clk) disable iff (rst)
        done_en |-> slot_q[done_idx].inuse);
endmodule

// File: rtl/rsb_oldest_pick.sv
`timescale 1ns/1ps
module rsb_oldest_pick
    import rsb_pkg::*;
(
    input  logic [SLOTS-1:0] cand_vec,
    input  tag_t             base,
    output logic             pick_valid,
    output tag_t             pick_idx
);
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = base;
        for (int k = 0; k < SLOTS; k++) begin
            if (!pick_valid && cand_vec[base + tag_t'(k)]) begin
                pick_valid = 1'b1;
                pick_idx   = base + tag_t'(k);
            end
        end
    end
endmodule

// File: rtl/rsb_ring_ctrl.sv
`timescale 1ns/1ps
module rsb_ring_ctrl
    import rsb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_req,
    input  logic [SLOTS-1:0] inuse_vec,
    output tag_t             aptr,
    output tag_t             dptr,
    output logic             alloc_ok
);
    localparam cnt_t FULL = cnt_t'(SLOTS);

    cnt_t occ_q;
    logic alloc_fire;
    logic free_fire;

    assign alloc_ok   = (occ_q != FULL);
    assign alloc_fire = alloc_req && alloc_ok;
    assign free_fire  = (occ_q != cnt_t'(0)) && !inuse_vec[dptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            aptr  <= '0;
            dptr  <= '0;
            occ_q <= '0;
        end else begin
            if (alloc_fire) aptr <= next_tag(aptr);
            if (free_fire)  dptr <= next_tag(dptr);
            case ({alloc_fire, free_fire})
                2'b10:   occ_q <= occ_q + cnt_t'(1);
                2'b01:   occ_q <= occ_q - cnt_t'(1);
                default: occ_q <= occ_q;
            endcase
        end
    end

    assert_dealloc_waits_R10: assert property (@(posedge clk) disable iff (rst)
        inuse_vec[dptr] |=> $stable(dptr));
endmodule

// File: rtl/rename_slot_buffer.sv
`timescale 1ns/1ps
module rename_slot_buffer
    import rsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic [REG_W-1:0]  alloc_dst,
    input  logic [REG_W-1:0]  alloc_src_a,
    input  logic [REG_W-1:0]  alloc_src_b,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    output logic              disp_valid,
    input  logic              disp_accept,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_opnd_a,
    output logic [DATA_W-1:0] disp_opnd_b,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    input  logic              done_valid,
    input  logic [TAG_W-1:0]  done_tag
);
    tag_t             aptr;
    tag_t             dptr;
    logic             alloc_ok;
    logic             alloc_fire;
    logic             start_fire;
    logic [SLOTS-1:0] inuse_vec;
    logic [SLOTS-1:0] cand_vec;
    op_t   [SLOTS-1:0] op_vec;
    data_t [SLOTS-1:0] a_vec;
    data_t [SLOTS-1:0] b_vec;
    operand_t         rd_a;
    operand_t         rd_b;
    bcast_t           bc;
    logic             pick_valid;
    tag_t             pick_idx;

    assign bc.valid   = res_valid;
    assign bc.tag     = res_tag;
    assign bc.data    = res_data;
    assign alloc_fire = alloc_valid && alloc_ok;
    assign start_fire = pick_valid && disp_accept;

    rsb_ring_ctrl ring_i (
        .clk       (clk),
        .rst       (rst),
        .alloc_req (alloc_valid),
        .inuse_vec (inuse_vec),
        .aptr      (aptr),
        .dptr      (dptr),
        .alloc_ok  (alloc_ok)
    );

    rsb_rename_table rename_i (
        .clk      (clk),
        .rst      (rst),
        .bc       (bc),
        .wr_en    (alloc_fire),
        .wr_reg   (alloc_dst),
        .wr_tag   (aptr),
        .rd_reg_a (alloc_src_a),
        .rd_reg_b (alloc_src_b),
        .rd_a     (rd_a),
        .rd_b     (rd_b)
    );

    rsb_slot_array slots_i (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (alloc_fire),
        .alloc_idx (aptr),
        .alloc_op  (alloc_op),
        .alloc_a   (rd_a),
        .alloc_b   (rd_b),
        .bc        (bc),
        .start_en  (start_fire),
        .start_idx (pick_idx),
        .done_en   (done_valid),
        .done_idx  (done_tag),
        .inuse_vec (inuse_vec),
        .cand_vec  (cand_vec),
        .op_vec    (op_vec),
        .a_vec     (a_vec),
        .b_vec     (b_vec)
    );

    rsb_oldest_pick pick_i (
        .cand_vec   (cand_vec),
        .base       (dptr),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    assign alloc_ready = alloc_ok;
    assign alloc_tag   = aptr;
    assign disp_valid  = pick_valid;
    assign disp_tag    = pick_idx;
    assign disp_op     = op_vec[pick_idx];
    assign disp_opnd_a = a_vec[pick_idx];
    assign disp_opnd_b = b_vec[pick_idx];

    assert_tag_steps_R2: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready) |=> alloc_tag == next_tag($past(alloc_tag)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !alloc_ready) |=> $stable(alloc_tag));
endmodule

// File: tb/rename_slot_buffer_tb_top.sv
`timescale 1ns/1ps
module rename_slot_buffer_tb_top;
    import rsb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              alloc_valid = 1'b0;
    logic [OP_W-1:0]   alloc_op = '0;
    logic [REG_W-1:0]  alloc_dst = '0;
    logic [REG_W-1:0]  alloc_src_a = '0;
    logic [REG_W-1:0]  alloc_src_b = '0;
    logic              alloc_ready;
    logic [TAG_W-1:0]  alloc_tag;
    logic              disp_valid;
    logic              disp_accept = 1'b0;
    logic [TAG_W-1:0]  disp_tag;
    logic [OP_W-1:0]   disp_op;
    logic [DATA_W-1:0] disp_opnd_a;
    logic [DATA_W-1:0] disp_opnd_b;
    logic              res_valid = 1'b0;
    logic [TAG_W-1:0]  res_tag = '0;
    logic [DATA_W-1:0] res_data = '0;
    logic              done_valid = 1'b0;
    logic [TAG_W-1:0]  done_tag = '0;

    int checks = 0;
    int failures = 0;
    int exp_tag = 0;
    int model [REGS];
    bit finished = 0;

    always #2.5 clk = ~clk;

    rename_slot_buffer dut_i (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_dst(alloc_dst),
        .alloc_src_a(alloc_src_a), .alloc_src_b(alloc_src_b),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .disp_valid(disp_valid), .disp_accept(disp_accept), .disp_tag(disp_tag),
        .disp_op(disp_op), .disp_opnd_a(disp_opnd_a), .disp_opnd_b(disp_opnd_b),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .done_valid(done_valid), .done_tag(done_tag)
    );

    // {op[31:28], dst[27:24], src_a[23:20], src_b[19:16], result[15:0]}
    localparam logic [31:0] VECS [6] = '{
        32'h1123_00A5, 32'h2211_0B0B, 32'h3320_1234,
        32'h4131_00FF, 32'h5012_7777, 32'h6504_4242
    };

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_alloc(input int op, input int dst, input int sa, input int sb,
                            output int tag);
        alloc_valid = 1'b1;
        alloc_op    = OP_W'(op);
        alloc_dst   = REG_W'(dst);
        alloc_src_a = REG_W'(sa);
        alloc_src_b = REG_W'(sb);
        tag = int'(alloc_tag);
        exp_tag = (exp_tag + 1) % SLOTS;
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic do_accept();
        disp_accept = 1'b1; tick(); disp_accept = 1'b0;
    endtask

    task automatic do_result(input int tag, input int data);
        res_valid = 1'b1; res_tag = TAG_W'(tag); res_data = DATA_W'(data);
        tick();
        res_valid = 1'b0;
    endtask

    task automatic do_done(input int tag);
        done_valid = 1'b1; done_tag = TAG_W'(tag); tick(); done_valid = 1'b0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        int ta, tb, tc, td, te, tx, ty, tz, t0, tf;
        for (int i = 0; i < REGS; i++) model[i] = i;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        chk("R1 alloc_ready", int'(alloc_ready), 1);
        chk("R1 alloc_tag", int'(alloc_tag), 0);
        chk("R1 disp_valid", int'(disp_valid), 0);

        // Table walk: one instruction at a time through the buffer
        for (int v = 0; v < 6; v++) begin
            int op, dst, sa, sb, res, tag, want;
            op  = int'(VECS[v][31:28]);
            dst = int'(VECS[v][27:24]);
            sa  = int'(VECS[v][23:20]);
            sb  = int'(VECS[v][19:16]);
            res = int'(VECS[v][15:0]);
            want = exp_tag;
            do_alloc(op, dst, sa, sb, tag);
            chk("R2 tag sequence", tag, want);
            chk("R4 ready slot offered", int'(disp_valid), 1);
            chk("R2 disp_tag", int'(disp_tag), want);
            chk("R4 disp_op", int'(disp_op), op);
            chk("R6 operand a from table", int'(disp_opnd_a), model[sa]);
            chk("R6 operand b from table", int'(disp_opnd_b), model[sb]);
            do_accept();
            chk("R4 not offered twice", int'(disp_valid), 0);
            do_result(tag, res);
            do_done(tag);
            model[dst] = res;
        end

        // R5 / R7 / R3: two writers of r1, stale broadcast of the older one
        do_alloc(1, 1, 2, 3, ta);
        do_alloc(2, 1, 2, 3, tb);
        chk("R5 oldest first", int'(disp_tag), ta);
        do_accept();
        chk("R5 next oldest", int'(disp_tag), tb);
        do_accept();
        do_result(ta, 16'h0111);
        do_alloc(3, 4, 1, 2, tc);
        chk("R7 reader still waits", int'(disp_valid), 0);
        do_result(tb, 16'h0222);
        chk("R3 released by younger tag", int'(disp_valid), 1);
        chk("R3 disp_tag", int'(disp_tag), tc);
        chk("R3 operand from broadcast", int'(disp_opnd_a), 16'h0222);
        chk("R3 operand b", int'(disp_opnd_b), model[2]);
        do_accept();
        do_result(tc, 16'h0333);
        do_done(ta); do_done(tb); do_done(tc);
        model[1] = 16'h0222; model[4] = 16'h0333;

        // R8: broadcast and dependent allocation in the same cycle
        do_alloc(4, 5, 6, 6, td);
        do_accept();
        res_valid = 1'b1; res_tag = TAG_W'(td); res_data = 16'h0444;
        alloc_valid = 1'b1; alloc_op = 4'd5; alloc_dst = 3'd7;
        alloc_src_a = 3'd5; alloc_src_b = 3'd6;
        te = int'(alloc_tag);
        exp_tag = (exp_tag + 1) % SLOTS;
        tick();
        res_valid = 1'b0; alloc_valid = 1'b0;
        chk("R8 bypassed slot ready", int'(disp_valid), 1);
        chk("R8 disp_tag", int'(disp_tag), te);
        chk("R8 bypassed operand", int'(disp_opnd_a), 16'h0444);
        do_accept();
        do_result(te, 16'h0555);
        do_done(td); do_done(te);
        model[5] = 16'h0444; model[7] = 16'h0555;

        // R4 / R5: skip a waiting slot for a later ready one
        do_alloc(7, 2, 0, 0, tx);
        do_alloc(8, 3, 2, 1, ty);
        do_alloc(9, 4, 1, 1, tz);
        chk("R5 oldest ready offered", int'(disp_tag), tx);
        do_accept();
        chk("R4 waiting slot skipped", int'(disp_tag), tz);
        do_accept();
        do_result(tx, 16'h0C0C);
        chk("R3 waiter offered after result", int'(disp_tag), ty);
        chk("R3 waiter operand", int'(disp_opnd_a), 16'h0C0C);
        do_accept();
        do_result(ty, 16'h0D0D);
        do_result(tz, 16'h0E0E);
        do_done(tx); do_done(ty); do_done(tz);
        model[2] = 16'h0C0C; model[3] = 16'h0D0D; model[4] = 16'h0E0E;

        // R9 / R10 / R11: fill, out-of-order completion, in-order reclaim
        repeat (3) tick();
        t0 = exp_tag;
        for (int k = 0; k < SLOTS; k++) begin
            int tq;
            do_alloc(1, 0, 1, 1, tq);
        end
        chk("R9 full stalls", int'(alloc_ready), 0);
        alloc_valid = 1'b1; tick(); alloc_valid = 1'b0;
        exp_tag = t0;
        chk("R9 tag unchanged when full", int'(alloc_tag), t0);
        do_done((t0 + 1) % SLOTS);
        tick();
        chk("R10 younger free keeps stall", int'(alloc_ready), 0);
        do_done(t0);
        chk("R10 reclaim not yet", int'(alloc_ready), 0);
        tick();
        chk("R10 reclaim after oldest", int'(alloc_ready), 1);
        chk("R11 tag reused", int'(alloc_tag), t0);
        do_result((t0 + SLOTS - 1) % SLOTS, 16'h0077);
        for (int k = 2; k < SLOTS; k++) do_done((t0 + k) % SLOTS);
        model[0] = 16'h0077;
        do_alloc(2, 6, 0, 0, tf);
        chk("R11 reused slot offered", int'(disp_tag), t0);
        chk("R6 converted mapping", int'(disp_opnd_a), model[0]);
        do_accept();
        do_result(tf, 16'h0001);
        do_done(tf);

        report();
    end
endmodule